// File: doc/BRIEF.md
# Change-of-State GPIO Monitor

This block is a general-purpose IO port of sixteen lines (the line count is a parameter) with a change-of-state engine attached. Each line has an output data bit and a drive-enable bit. Whether or not a line is driven, its input is always readable through a synchroniser. The engine samples the synchronised inputs on a tick from a programmable divider. For each line it can report rising or falling transitions between two consecutive samples, or a sustained active level. Events are latched into sticky status bits, and a mask turns selected status bits into a single interrupt request.

Software reaches the block through a simple register port: a write strobe with an address and data, and a read data bus that is combinational from the address. Level mode is meant for lines that need attention for as long as they are asserted. A per-line inversion bit lets either sense count as active. Edge mode suits lines whose transitions matter.

Top module: `cos_gpio_port`

## Requirements
- R1: After reset every register reads zero, `pad_out` and `pad_oe` are zero and `irq` is low.
- R2: A write to address 0x0 sets `pad_out` and a write to address 0x1 sets `pad_oe`, one bit per line, effective at the clock edge of the write; address 0x1 reads back the drive enables.
- R3: Address 0x2 reads the input lines through a two-stage synchroniser, whatever the drive enables hold.
- R4: With a line in edge mode (bit clear at address 0x3), a 0-to-1 change between consecutive samples sets its status bit when its bit at address 0x4 is set. A 1-to-0 change sets it when its bit at address 0x5 is set. A transition of a kind that is not enabled leaves the status bit unchanged.
- R5: Status at address 0x8 is sticky: writing a one to a bit clears it, and writing a zero leaves it unchanged.
- R6: An event that arrives at the same clock edge as a clear of its status bit leaves the bit set.
- R7: With a line in level mode (bit set at address 0x3), its status bit is set while the line's qualified level is one, and it returns at once after a clear for as long as that level holds.
- R8: The qualified level is the sampled input XOR the line's bit at address 0x6. This inversion has no effect on a line in edge mode.
- R9: `irq` is high exactly when some status bit is set together with its bit at address 0x7.
- R10: Inputs are sampled once every N+1 clocks, where N is the value at address 0x9. Writing that address restarts the count, so a change is first sampled N+1 clocks after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| pad_in | input | 16 | Line inputs from the pads |
| pad_out | output | 16 | Line output values |
| pad_oe | output | 16 | Line drive enables |
| irq | output | 1 | Interrupt request |

## Verification
The engine is driven with several patterns. Simultaneous rises on lines with mixed enables show that the rise and fall selections are independent per line. A falling pattern on the same lines confirms the opposite selection. A transition timed to land on the exact edge of a clear checks the priority of events over clears. A held level that is cleared while still active separates level mode from edge mode. An inverted idle-low line shows that polarity acts only in level mode. A slow divider with a change placed just after the divider write, read once before and once after the expected sample point, shows that sampling follows the programmed rate rather than every clock.

// File: rtl/cosg_pkg.sv
package cosg_pkg;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      RA_OUT   = 4'h0,
      RA_DIR   = 4'h1,
      RA_PIN   = 4'h2,
      RA_MODE  = 4'h3,
      RA_RISE  = 4'h4,
      RA_FALL  = 4'h5,
      RA_POL   = 4'h6,
      RA_IRQEN = 4'h7,
      RA_STAT  = 4'h8,
      RA_DIV   = 4'h9
   } reg_addr_e;
endpackage

// File: rtl/cosg_sync.sv
module cosg_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cosg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cosg_tick.sv
module cosg_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] load_val,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt == '0) && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (load)      cnt <= load_val;
      else if (cnt == '0) cnt <= div;
      else                cnt <= cnt - 1'b1;
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> !tick); // R10
endmodule

// File: rtl/cosg_detect.sv
module cosg_detect #(
   parameter int LINES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [LINES-1:0] din,
   input  logic [LINES-1:0] level_mode,
   input  logic [LINES-1:0] rise_en,
   input  logic [LINES-1:0] fall_en,
   input  logic [LINES-1:0] invert,
   output logic [LINES-1:0] edge_evt,
   output logic [LINES-1:0] lvl_evt
);
   logic [LINES-1:0] samp;
   logic             primed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp   <= '0;
         primed <= 1'b0;
      end else if (tick) begin
         samp   <= din;
         primed <= 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         logic rose, dropped;
         assign rose        = din[i] & ~samp[i];
         assign dropped     = ~din[i] & samp[i];
         assign edge_evt[i] = ~level_mode[i] & primed & tick &
                              ((rise_en[i] & rose) | (fall_en[i] & dropped));
         assign lvl_evt[i]  = level_mode[i] & primed & (samp[i] ^ invert[i]);
      end
   endgenerate

   AST_EDGE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_evt) |-> tick); // R10

   AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_evt & lvl_evt) == '0); // R4
endmodule

// File: rtl/cos_gpio_port.sv
module cos_gpio_port
   import cosg_pkg::*;
#(
   parameter int LINES       = 16,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [LINES-1:0]  reg_wdata,
   output logic [LINES-1:0]  reg_rdata,
   input  logic [LINES-1:0]  pad_in,
   output logic [LINES-1:0]  pad_out,
   output logic [LINES-1:0]  pad_oe,
   output logic              irq
);
   generate
      if (LINES < 1 || LINES > 32) begin : g_bad_lines
         $error("cos_gpio_port: LINES out of range 1..32");
      end
      if (DIV_W < 1 || DIV_W > LINES) begin : g_bad_div
         $error("cos_gpio_port: DIV_W must fit in the register width");
      end
   endgenerate

   logic [LINES-1:0] out_r, dir_r, mode_r, rise_r, fall_r, pol_r, irqen_r, stat_r;
   logic [DIV_W-1:0] div_r;
   logic [LINES-1:0] din, edge_evt, lvl_evt, clr_mask;
   logic             tick, div_load;

   assign div_load = reg_wr && (reg_addr == RA_DIV);
   assign clr_mask = (reg_wr && reg_addr == RA_STAT) ? reg_wdata : '0;

   cosg_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din));

   cosg_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .load(div_load),
      .load_val(reg_wdata[DIV_W-1:0]), .div(div_r), .tick(tick));

   cosg_detect #(.LINES(LINES)) u_det (
      .clk(clk), .rst_n(rst_n), .tick(tick), .din(din),
      .level_mode(mode_r), .rise_en(rise_r), .fall_en(fall_r), .invert(pol_r),
      .edge_evt(edge_evt), .lvl_evt(lvl_evt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_r <= '0; dir_r <= '0; mode_r <= '0; rise_r <= '0;
         fall_r <= '0; pol_r <= '0; irqen_r <= '0; div_r <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            RA_OUT:   out_r   <= reg_wdata;
            RA_DIR:   dir_r   <= reg_wdata;
            RA_MODE:  mode_r  <= reg_wdata;
            RA_RISE:  rise_r  <= reg_wdata;
            RA_FALL:  fall_r  <= reg_wdata;
            RA_POL:   pol_r   <= reg_wdata;
            RA_IRQEN: irqen_r <= reg_wdata;
            RA_DIV:   div_r   <= reg_wdata[DIV_W-1:0];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_r <= '0;
      else        stat_r <= (stat_r & ~clr_mask) | edge_evt | lvl_evt;
   end

   always_comb begin
      case (reg_addr)
         RA_OUT:   reg_rdata = out_r;
         RA_DIR:   reg_rdata = dir_r;
         RA_PIN:   reg_rdata = din;
         RA_MODE:  reg_rdata = mode_r;
         RA_RISE:  reg_rdata = rise_r;
         RA_FALL:  reg_rdata = fall_r;
         RA_POL:   reg_rdata = pol_r;
         RA_IRQEN: reg_rdata = irqen_r;
         RA_STAT:  reg_rdata = stat_r;
         RA_DIV:   reg_rdata = LINES'(div_r);
         default:  reg_rdata = '0;
      endcase
   end

   assign pad_out = out_r;
   assign pad_oe  = dir_r;
   assign irq     = |(stat_r & irqen_r);

   AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == RA_DIR) |=> (pad_oe == $past(reg_wdata))); // R2

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(stat_r) & ~stat_r) & ~$past(clr_mask)) == '0)); // R5

   AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (|((edge_evt | lvl_evt) & clr_mask)) |=>
         ((stat_r & $past(edge_evt | lvl_evt)) == $past(edge_evt | lvl_evt))); // R6

   AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|lvl_evt) |=> ((stat_r & $past(lvl_evt)) == $past(lvl_evt))); // R7

   AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (stat_r != '0)); // R9
endmodule

// File: tb/tb_cos_gpio_port.sv
module tb_cos_gpio_port;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr;
   logic [3:0]  reg_addr;
   logic [15:0] reg_wdata;
   logic [15:0] reg_rdata;
   logic [15:0] pad_in;
   logic [15:0] pad_out;
   logic [15:0] pad_oe;
   logic        irq;

   always #2.5 clk = ~clk;

   cos_gpio_port dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

   typedef struct {
      int          kind;
      logic [15:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;

   localparam logic [3:0] A_OUT = 4'h0, A_DIR = 4'h1, A_PIN = 4'h2, A_MODE = 4'h3,
      A_RISE = 4'h4, A_FALL = 4'h5, A_POL = 4'h6, A_IRQEN = 4'h7, A_STAT = 4'h8,
      A_DIV = 4'h9;

   // monitor: pops expected items and compares against the live outputs
   initial begin
      forever begin
         item_t it;
         logic [15:0] act;
         wait (q.size() > 0);
         it = q.pop_front();
         case (it.kind)
            0:       act = reg_rdata;
            1:       act = {15'd0, irq};
            2:       act = pad_out;
            default: act = pad_oe;
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic expect_item(input int kind, input logic [3:0] a,
                              input logic [15:0] e, input string tag);
      item_t it;
      reg_addr = a;
      #1;
      it.kind = kind; it.exp = e; it.tag = tag;
      q.push_back(it);
      wait (q.size() == 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; pad_in = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      expect_item(0, A_STAT, 16'h0000, "R1 status");
      expect_item(0, A_OUT,  16'h0000, "R1 out reg");
      expect_item(0, A_DIV,  16'h0000, "R1 divider");
      expect_item(3, A_OUT,  16'h0000, "R1 pad_oe");
      expect_item(1, A_OUT,  16'h0000, "R1 irq");

      // R2 drive registers
      wr(A_OUT, 16'hA5A5);
      wr(A_DIR, 16'hFF00);
      expect_item(2, A_OUT, 16'hA5A5, "R2 pad_out");
      expect_item(3, A_OUT, 16'hFF00, "R2 pad_oe");
      expect_item(0, A_DIR, 16'hFF00, "R2 dir readback");

      // R3 input readback independent of drive enables
      pad_in = 16'h1234;
      repeat (3) @(negedge clk);
      expect_item(0, A_PIN, 16'h1234, "R3 pin readback");
      pad_in = 16'h0000;
      repeat (4) @(negedge clk);

      // R4 edge selection per line
      wr(A_RISE, 16'h0005);
      wr(A_FALL, 16'h0006);
      wr(A_STAT, 16'hFFFF);
      expect_item(0, A_STAT, 16'h0000, "R4 clean start");
      pad_in = 16'h0007;
      repeat (5) @(negedge clk);
      expect_item(0, A_STAT, 16'h0005, "R4 rising select");
      wr(A_STAT, 16'hFFFF);
      expect_item(0, A_STAT, 16'h0000, "R5 clear all");
      pad_in = 16'h0000;
      repeat (5) @(negedge clk);
      expect_item(0, A_STAT, 16'h0006, "R4 falling select");

      // R5 write-one-to-clear
      wr(A_STAT, 16'h0002);
      expect_item(0, A_STAT, 16'h0004, "R5 partial clear");
      wr(A_STAT, 16'h0000);
      expect_item(0, A_STAT, 16'h0004, "R5 zero write ignored");
      wr(A_STAT, 16'hFFFF);
      expect_item(1, A_OUT, 16'h0000, "R9 irq low no status");

      // R6 event lands on the clear edge
      pad_in = 16'h0001;
      @(negedge clk);
      @(negedge clk);
      wr(A_STAT, 16'h0001);
      expect_item(0, A_STAT, 16'h0001, "R6 event beats clear");

      // R9 interrupt masking
      expect_item(1, A_OUT, 16'h0000, "R9 irq masked");
      wr(A_IRQEN, 16'h0001);
      expect_item(1, A_OUT, 16'h0001, "R9 irq enabled");
      wr(A_IRQEN, 16'h0002);
      expect_item(1, A_OUT, 16'h0000, "R9 irq other mask");
      wr(A_STAT, 16'hFFFF);
      pad_in = 16'h0000;
      repeat (5) @(negedge clk);
      wr(A_STAT, 16'hFFFF);
      expect_item(0, A_STAT, 16'h0000, "R4 disabled fall ignored");

      // R7 level mode
      wr(A_MODE, 16'h0010);
      pad_in = 16'h0010;
      repeat (5) @(negedge clk);
      expect_item(0, A_STAT, 16'h0010, "R7 level sets");
      wr(A_STAT, 16'h0010);
      expect_item(0, A_STAT, 16'h0010, "R7 level survives clear");
      pad_in = 16'h0000;
      repeat (5) @(negedge clk);
      wr(A_STAT, 16'hFFFF);
      expect_item(0, A_STAT, 16'h0000, "R7 released level clears");

      // R8 polarity
      wr(A_RISE, 16'h0025);
      wr(A_POL, 16'h0020);
      repeat (3) @(negedge clk);
      expect_item(0, A_STAT, 16'h0000, "R8 polarity ignored in edge mode");
      wr(A_MODE, 16'h0030);
      repeat (3) @(negedge clk);
      expect_item(0, A_STAT, 16'h0020, "R8 inverted level active low");
      wr(A_MODE, 16'h0000);
      wr(A_POL, 16'h0000);
      wr(A_STAT, 16'hFFFF);
      expect_item(0, A_STAT, 16'h0000, "R8 cleanup");

      // R10 sample rate
      wr(A_RISE, 16'h0100);
      wr(A_DIV, 16'd49);
      pad_in = 16'h0100;
      repeat (28) @(negedge clk);
      expect_item(0, A_STAT, 16'h0000, "R10 not yet sampled");
      repeat (30) @(negedge clk);
      expect_item(0, A_STAT, 16'h0100, "R10 sampled at tick");
      expect_item(0, A_DIV, 16'd49, "R10 divider readback");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule